// File: doc/BRIEF.md
# Interrupt Source Configuration Unit

This unit is a single source channel of a programmable interrupt controller. It brings one asynchronous external interrupt line into the clock domain and qualifies it by trigger type (edge or level) and by active polarity. It keeps a request pending and offers that request, together with the source's priority and vector, to an arbiter that is shared between channels. The arbiter picks among the channels and acknowledges the one it takes. The channel then holds the source in service until the arbiter signals that service is finished.

Software programs the channel through two 32-bit registers on a simple word bus. The configuration word holds the mask, polarity, trigger type, priority and vector. The routing word holds one bit per processor. Software changes fields with read-modify-write, so every writable field reads back exactly as written. A read-only activity flag in the configuration word is high while the source has a request pending or is in service. Before reprogramming a masked source, software waits for this flag to clear.

Top module: `intsrc_channel`

## Requirements
- R1: After reset the configuration word (addr_i=0) reads 0x8000_0000, which means masked with every other field zero. The routing word (addr_i=1) reads 0, and req_o is low.
- R2: The writable fields of the configuration word are mask bit 31, polarity bit 23, trigger bit 22, priority bits 19:16 and vector bits 7:0. Each reads back exactly as written from the clock edge after the write. All other bits read zero.
- R3: The routing word stores wdata_i[NUM_CPU-1:0], drives it on dest_o and reads it back. Higher bits read zero.
- R4: Bit 30 of the configuration word reads 1 exactly while a request is pending or the source is in service. Writes to bit 30 have no effect.
- R5: Polarity 1 makes a high level (or a rising edge) active. Polarity 0 makes a low level (or a falling edge) active.
- R6: With trigger bit 0 (edge), an active edge latches a pending request. The request stays pending after the line returns to inactive, and an accepted acknowledge clears it.
- R7: With trigger bit 1 (level), the pending state follows the qualified line level and is not latched.
- R8: While the mask bit is 1, req_o stays low but a pending request is kept. Clearing the mask forwards that request.
- R9: A source with priority 0 never raises req_o, even when it is unmasked.
- R10: A source whose routing word is zero never raises req_o.
- R11: ack_i while req_o is high puts the source in service, and req_o stays low until done_i. ack_i while req_o is low has no effect.
- R12: prio_o and vec_o always show the programmed priority and vector fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 1 | External interrupt line, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 configuration word, 1 routing word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ack_i | input | 1 | Arbiter takes this source |
| done_i | input | 1 | Arbiter ends service of this source |
| req_o | output | 1 | Forwarded request |
| prio_o | output | 4 | Programmed priority |
| vec_o | output | 8 | Programmed vector |
| dest_o | output | NUM_CPU | Processor routing mask |

## Verification
A register write takes effect at the next clock edge, and readback is combinational. The bench therefore reads in the low phase that follows the write. A change on irq_i passes SYNC_STAGES flops. It reaches a level-mode request after SYNC_STAGES edges and an edge-mode latch one edge later. The bench waits SYNC_STAGES+3 clocks after each line change before it samples req_o or the activity bit. An acknowledge or done pulse is driven for one low-to-low window, and its effect is checked at the next falling edge.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;
  localparam int PRIO_W     = 4;
  localparam int VEC_W      = 8;
  localparam int MASK_POS   = 31;
  localparam int ACT_POS    = 30;
  localparam int POL_POS    = 23;
  localparam int SENSE_POS  = 22;
  localparam int PRIO_LSB   = 16;
  localparam int VEC_LSB    = 0;

  typedef struct packed {
    logic              mask;
    logic              pol;
    logic              sense;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } src_cfg_t;

  typedef enum logic {
    REG_CFG  = 1'b0,
    REG_DEST = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/intsrc_sync.sv
module intsrc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain <= '0;
        else         chain <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain <= '0;
        else         chain <= {chain[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/intsrc_regs.sv
module intsrc_regs
  import intsrc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               active_i,
  output src_cfg_t           cfg_o,
  output logic [NUM_CPU-1:0] dest_o,
  output logic [31:0]        rdata_o
);
  localparam src_cfg_t CFG_RST = '{mask: 1'b1, pol: 1'b0, sense: 1'b0, prio: '0, vec: '0};

  reg_sel_e sel;
  logic     unused_wdata;

  assign sel          = reg_sel_e'(addr_i);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= CFG_RST;
      dest_o <= '0;
    end else if (wr_en_i) begin
      if (sel == REG_CFG) begin
        cfg_o.mask  <= wdata_i[MASK_POS];
        cfg_o.pol   <= wdata_i[POL_POS];
        cfg_o.sense <= wdata_i[SENSE_POS];
        cfg_o.prio  <= wdata_i[PRIO_LSB +: PRIO_W];
        cfg_o.vec   <= wdata_i[VEC_LSB +: VEC_W];
      end else begin
        dest_o <= wdata_i[NUM_CPU-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel == REG_CFG) begin
      rdata_o[MASK_POS]              = cfg_o.mask;
      rdata_o[ACT_POS]               = active_i;
      rdata_o[POL_POS]               = cfg_o.pol;
      rdata_o[SENSE_POS]             = cfg_o.sense;
      rdata_o[PRIO_LSB +: PRIO_W]    = cfg_o.prio;
      rdata_o[VEC_LSB +: VEC_W]      = cfg_o.vec;
    end else begin
      rdata_o[NUM_CPU-1:0] = dest_o;
    end
  end

  assert_cfg_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == REG_CFG) |=>
      (cfg_o.mask == $past(wdata_i[MASK_POS]) &&
       cfg_o.prio == $past(wdata_i[PRIO_LSB +: PRIO_W]) &&
       cfg_o.vec  == $past(wdata_i[VEC_LSB +: VEC_W])));

  assert_dest_readback_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == REG_DEST) |=> dest_o == $past(wdata_i[NUM_CPU-1:0]));

  assert_dest_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(dest_o));
endmodule

// File: rtl/intsrc_trigger.sv
module intsrc_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic sense_i,
  input  logic pol_i,
  input  logic fwd_ok_i,
  input  logic ack_i,
  input  logic done_i,
  output logic pending_o,
  output logic in_service_o,
  output logic req_o
);
  logic line_prev, edge_hit, qual, edge_latch, ack_take;

  assign qual     = pol_i ? line_i : ~line_i;
  // edges come from raw samples so a polarity rewrite makes no false edge
  assign edge_hit = pol_i ? (line_i & ~line_prev) : (~line_i & line_prev);
  assign ack_take = ack_i & req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_prev    <= 1'b0;
      edge_latch   <= 1'b0;
      in_service_o <= 1'b0;
    end else begin
      line_prev <= line_i;
      if (sense_i)       edge_latch <= 1'b0;
      else if (edge_hit) edge_latch <= 1'b1;
      else if (ack_take) edge_latch <= 1'b0;
      if (ack_take)    in_service_o <= 1'b1;
      else if (done_i) in_service_o <= 1'b0;
    end
  end

  assign pending_o = sense_i ? qual : edge_latch;
  assign req_o     = pending_o & ~in_service_o & fwd_ok_i;

  assert_ack_clears_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_take && !sense_i && !edge_hit) |=> !edge_latch);

  assert_ack_in_service_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_take |=> (in_service_o && !req_o));

  assert_stray_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o && !in_service_o) |=> !in_service_o);
endmodule

// File: rtl/intsrc_channel.sv
module intsrc_channel
  import intsrc_pkg::*;
#(
  parameter int NUM_CPU     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               irq_i,
  input  logic               wr_en_i,
  input  logic               addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               ack_i,
  input  logic               done_i,
  output logic               req_o,
  output logic [PRIO_W-1:0]  prio_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_CPU-1:0] dest_o
);
  src_cfg_t cfg;
  logic     line_sync, pending, in_service, active, fwd_ok;

  intsrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (line_sync)
  );

  intsrc_regs #(.NUM_CPU(NUM_CPU)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .active_i(active),
    .cfg_o   (cfg),
    .dest_o  (dest_o),
    .rdata_o (rdata_o)
  );

  assign active = pending | in_service;
  assign fwd_ok = ~cfg.mask & (cfg.prio != '0) & (dest_o != '0);

  intsrc_trigger u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (line_sync),
    .sense_i     (cfg.sense),
    .pol_i       (cfg.pol),
    .fwd_ok_i    (fwd_ok),
    .ack_i       (ack_i),
    .done_i      (done_i),
    .pending_o   (pending),
    .in_service_o(in_service),
    .req_o       (req_o)
  );

  assign prio_o = cfg.prio;
  assign vec_o  = cfg.vec;

  assert_mask_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.mask |-> !req_o);

  assert_prio_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.prio == '0) |-> !req_o);

  assert_dest_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dest_o == '0) |-> !req_o);

  assert_req_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> rdata_o[ACT_POS] || addr_i);
endmodule

// File: tb/intsrc_channel_tb.sv
module intsrc_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CPU    = 4;
  localparam int SETTLE     = 5;

  logic clk = 1'b0, rst_n = 1'b0, irq = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic ack = 1'b0, done = 1'b0;
  logic [31:0] wdata = '0, rdata, v;
  logic req;
  logic [3:0] prio_o;
  logic [7:0] vec_o;
  logic [NUM_CPU-1:0] dest_o;
  int checks = 0, failures = 0;
  bit finished = 1'b0;
  bit cur_pol = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intsrc_channel #(.NUM_CPU(NUM_CPU), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack), .done_i(done), .req_o(req),
    .prio_o(prio_o), .vec_o(vec_o), .dest_o(dest_o)
  );

  function automatic logic [31:0] cfg_word(bit m, bit p, bit s, logic [3:0] pr, logic [7:0] ve);
    return {m, 1'b0, 6'b0, p, s, 2'b0, pr, 8'b0, ve};
  endfunction

  function automatic bit exp_fwd(bit m, logic [3:0] pr, logic [3:0] d);
    return !m && pr != 0 && d != 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(bit a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic settle(); repeat (SETTLE) @(negedge clk); endtask

  task automatic set_line(bit on); irq = cur_pol ? on : ~on; endtask

  task automatic pulse_ack(); @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0; endtask
  task automatic pulse_done(); @(negedge clk); done = 1'b1; @(negedge clk); done = 1'b0; endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, v); chk("R1 cfg reset", v, 32'h8000_0000);
    rd(1'b1, v); chk("R1 dest reset", v, 32'h0);
    chk("R1 req reset", {31'b0, req}, 32'h0);
    // R2 all-ones write: level, active-high, line low -> inactive
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk("R2 ones readback", v, 32'h80CF_00FF);
    // R3 upper routing bits dropped
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, v); chk("R3 dest readback", v, 32'h0000_000F);
    chk("R3 dest_o", {28'b0, dest_o}, 32'hF);
    // R4 write to activity bit ignored (edge, falling, line idle low)
    wr(1'b0, 32'h4000_0000);
    rd(1'b0, v); chk("R4 act write ignored", v, 32'h0);
    // R11 stray acknowledge ignored
    pulse_ack();
    rd(1'b0, v); chk("R11 stray ack activity", {31'b0, v[30]}, 32'h0);
    chk("R11 stray ack req", {31'b0, req}, 32'h0);

    for (int it = 0; it < 60; it++) begin
      bit m, p, s, fwd;
      logic [3:0] pr, d;
      logic [7:0] ve;
      p  = 1'($urandom % 2);
      s  = 1'($urandom % 2);
      m  = ($urandom % 4) == 0;
      pr = ($urandom % 4) == 0 ? 4'd0 : 4'($urandom % 16);
      d  = ($urandom % 5) == 0 ? 4'd0 : 4'($urandom % 16);
      ve = 8'($urandom);
      fwd = exp_fwd(m, pr, d);
      wr(1'b1, {28'b0, d});
      wr(1'b0, cfg_word(m, p, s, pr, ve));
      cur_pol = p;
      set_line(1'b0);
      settle();
      rd(1'b0, v); chk("R2 cfg readback", v, cfg_word(m, p, s, pr, ve));
      chk("R4 idle activity", {31'b0, v[30]}, 32'h0);
      chk("R12 prio/vec", {20'b0, prio_o, vec_o}, {20'b0, pr, ve});
      chk("R5 idle req", {31'b0, req}, 32'h0);
      set_line(1'b1);
      settle();
      rd(1'b0, v); chk("R5 active activity", {31'b0, v[30]}, 32'h1);
      chk("R8 R9 R10 forward", {31'b0, req}, {31'b0, fwd});
      set_line(1'b0);
      settle();
      rd(1'b0, v);
      if (s) begin
        chk("R7 level drop activity", {31'b0, v[30]}, 32'h0);
        chk("R7 level drop req", {31'b0, req}, 32'h0);
      end else begin
        chk("R6 edge held activity", {31'b0, v[30]}, 32'h1);
        chk("R6 edge held req", {31'b0, req}, {31'b0, fwd});
      end
      if (fwd) begin
        set_line(1'b1);
        settle();
        pulse_ack();
        rd(1'b0, v);
        chk("R11 in service req", {31'b0, req}, 32'h0);
        chk("R11 in service activity", {31'b0, v[30]}, 32'h1);
        @(negedge clk); done = 1'b1; set_line(1'b0);
        @(negedge clk); done = 1'b0;
        settle();
        rd(1'b0, v); chk("R6 after service activity", {31'b0, v[30]}, 32'h0);
      end else if (!s) begin
        wr(1'b1, 32'h1);
        wr(1'b0, cfg_word(1'b0, p, s, 4'd1, ve));
        chk("R8 held pending forwarded", {31'b0, req}, 32'h1);
        pulse_ack();
        pulse_done();
        rd(1'b0, v); chk("R6 ack cleared activity", {31'b0, v[30]}, 32'h0);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule